// File: doc/BRIEF.md
# Stepped crossbar sum-of-products evaluator

This block is a cycle-accurate digital model of a resistive crossbar that computes a sum-of-products Boolean function. Every cell is modelled as one bit. A low-resistance cell reads as 0 and a high-resistance cell reads as 1. The block is sized by three parameters: the input count `N_IN`, the minterm count `N_MT` and the output count `N_OUT`.

Each minterm row is configured while the block is idle. A configuration write supplies three things for one row:
- a literal-select mask;
- a polarity mask;
- the set of outputs that the minterm belongs to.

One `start` pulse then runs a fixed walk of seven steps, whatever the function is:
1. INIT forces all cells to 1.
2. LOAD captures true and complemented copies of the inputs.
3. CONF latches the selected literal of every row in parallel.
4. NAND evaluates every row as a NAND gate.
5. AND combines, for each output, the NAND results of its member rows. This gives the complement of the function.
6. INV inverts that complement.
7. EMIT presents the result together with a one-cycle `done`.

The controller has eight named states: IDLE, INIT, LOAD, CONF, NAND, AND, INV and EMIT. Its transitions are:
- IDLE goes to INIT when `start` is high.
- IDLE stays in IDLE otherwise.
- Each state from INIT to INV moves to the next state unconditionally.
- EMIT returns to IDLE.

A multi-level function is built by chaining blocks in series: the outputs of one block feed the inputs of the next. The total latency is then seven cycles for each block in the chain.

Top module: `xbar_sop_eval`

## Requirements
- R1: After `start` is sampled high in IDLE, `phase` steps through 1,2,3,4,5,6,7 on successive cycles and then returns to 0. The encoding is IDLE=0, INIT=1, LOAD=2, CONF=3, NAND=4, AND=5, INV=6, EMIT=7. An evaluation therefore takes exactly seven cycles, independent of the function.
- R2: `start` has no effect while `phase` is not 0.
- R3: A configuration write (`cfg_we` high) changes row `cfg_idx` only while `phase` is 0. Writes made in any other phase are dropped.
- R4: In row m, input bit i is a literal when bit i of the mask is 1. Polarity bit i = 1 selects the true input and 0 selects its complement. The row's product is the AND of its selected literals.
- R5: A row whose mask is all zeros is a constant-true product.
- R6: `out_vec[o]` is the OR of the products of the rows whose membership bit o is 1. An output with no member rows gives 0.
- R7: `done` is high for exactly one cycle, in the EMIT step. In that same cycle `out_vec` carries the result for the inputs applied at LOAD.
- R8: After EMIT, `out_vec` holds its value until the EMIT step of the next evaluation. This holds through input changes and through the intermediate steps.
- R9: After reset, `phase` is 0, `done` is 0 and `out_vec` is all zeros.
- R10: Every evaluation starts from cells forced to 1 in INIT. The result therefore depends only on the current inputs and configuration, not on earlier evaluations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | $clog2(N_MT) | Row addressed by the write |
| cfg_mask | input | N_IN | Literal-select mask for the row |
| cfg_pol | input | N_IN | Polarity for each selected literal |
| cfg_mem | input | N_OUT | Outputs that this row feeds |
| start | input | 1 | Launch one evaluation |
| in_vec | input | N_IN | Function inputs, captured in LOAD |
| phase | output | 3 | Current step (debug) |
| done | output | 1 | One-cycle pulse in EMIT |
| out_vec | output | N_OUT | Function result |

## Verification
A cell left in a wrong state reaches the ports only at the next EMIT, seven cycles after `start`:
- a bad literal cell or NAND cell flips the output bits of the outputs that row belongs to, and only for those inputs where the row decides the OR;
- a stale cell left over from a previous run shows up only when consecutive evaluations use different inputs.

For these reasons the sweeps cover every input vector under several configurations, in sequence. A sequencing fault shows at the ports as a `done` in the wrong cycle or a `phase` value out of order. This is visible within the first seven cycles.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_INIT = 3'd1,
        PH_LOAD = 3'd2,
        PH_CONF = 3'd3,
        PH_NAND = 3'd4,
        PH_AND  = 3'd5,
        PH_INV  = 3'd6,
        PH_EMIT = 3'd7
    } phase_e;
endpackage

// File: rtl/xbar_sop_ctrl.sv
module xbar_sop_ctrl
    import xbar_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start_i,
    output phase_e phase_o,
    output logic   done_o,
    output logic   idle_o
);
    phase_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PH_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PH_IDLE: st_d = start_i ? PH_INIT : PH_IDLE;
            PH_INIT: st_d = PH_LOAD;
            PH_LOAD: st_d = PH_CONF;
            PH_CONF: st_d = PH_NAND;
            PH_NAND: st_d = PH_AND;
            PH_AND:  st_d = PH_INV;
            PH_INV:  st_d = PH_EMIT;
            PH_EMIT: st_d = PH_IDLE;
        endcase
    end

    always_comb begin
        phase_o = st_q;
        done_o  = (st_q == PH_EMIT);
        idle_o  = (st_q == PH_IDLE);
    end

    logic [2:0] st_bits;
    assign st_bits = st_q;

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != PH_IDLE && st_q != PH_EMIT) |=> (st_bits == $past(st_bits) + 3'd1)); // R1
    AST_EMIT_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PH_EMIT) |=> (st_q == PH_IDLE)); // R1
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != PH_IDLE && start_i) |=> (st_q != PH_INIT)); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
endmodule

// File: rtl/xbar_mt_row.sv
module xbar_mt_row
    import xbar_pkg::*;
#(
    parameter int N_IN  = 3,
    parameter int N_OUT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we_i,
    input  logic [N_IN-1:0]  cfg_mask_i,
    input  logic [N_IN-1:0]  cfg_pol_i,
    input  logic [N_OUT-1:0] cfg_mem_i,
    input  phase_e           ph_i,
    input  logic [N_IN-1:0]  in_pos_i,
    input  logic [N_IN-1:0]  in_neg_i,
    output logic [N_OUT-1:0] mem_o,
    output logic             nand_o
);
    logic [N_IN-1:0]  mask_q, pol_q, lit_q;
    logic [N_OUT-1:0] mem_q;
    logic             nand_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            pol_q  <= '0;
            mem_q  <= '0;
        end else if (cfg_we_i) begin
            mask_q <= cfg_mask_i;
            pol_q  <= cfg_pol_i;
            mem_q  <= cfg_mem_i;
        end
    end

    for (genvar i = 0; i < N_IN; i++) begin : g_lit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                lit_q[i] <= 1'b1;
            else if (ph_i == PH_INIT)  lit_q[i] <= 1'b1;
            else if (ph_i == PH_CONF)
                lit_q[i] <= mask_q[i] ? (pol_q[i] ? in_pos_i[i] : in_neg_i[i]) : 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               nand_q <= 1'b1;
        else if (ph_i == PH_INIT) nand_q <= 1'b1;
        else if (ph_i == PH_NAND) nand_q <= ~&lit_q;
    end

    assign mem_o  = mem_q;
    assign nand_o = nand_q;

    AST_ROW_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_i == PH_INIT) |=> ((&lit_q) && nand_q)); // R10
    AST_ROW_CFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_i != PH_IDLE) |=> $stable({mask_q, pol_q, mem_q})); // R3
endmodule

// File: rtl/xbar_out_col.sv
module xbar_out_col
    import xbar_pkg::*;
#(
    parameter int N_MT = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  phase_e          ph_i,
    input  logic [N_MT-1:0] nand_i,
    input  logic [N_MT-1:0] mem_i,
    output logic            res_o
);
    logic and_q, out_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            and_q <= 1'b1;
            out_q <= 1'b1;
        end else begin
            unique case (ph_i)
                PH_INIT: begin
                    and_q <= 1'b1;
                    out_q <= 1'b1;
                end
                PH_AND:  and_q <= &(nand_i | ~mem_i);
                PH_INV:  out_q <= ~and_q;
                default: ;
            endcase
        end
    end

    assign res_o = out_q;

    AST_COL_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_i == PH_INIT) |=> (and_q && out_q)); // R10
    AST_COL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_i == PH_AND && mem_i == '0) |=> and_q); // R6
endmodule

// File: rtl/xbar_sop_eval.sv
module xbar_sop_eval
    import xbar_pkg::*;
#(
    parameter int N_IN  = 3,
    parameter int N_MT  = 4,
    parameter int N_OUT = 2,
    localparam int IDX_W = (N_MT > 1) ? $clog2(N_MT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [N_IN-1:0]  cfg_mask,
    input  logic [N_IN-1:0]  cfg_pol,
    input  logic [N_OUT-1:0] cfg_mem,
    input  logic             start,
    input  logic [N_IN-1:0]  in_vec,
    output logic [2:0]       phase,
    output logic             done,
    output logic [N_OUT-1:0] out_vec
);
    phase_e           ph;
    logic             idle, emit;
    logic [N_IN-1:0]  pos_q, neg_q;
    logic [N_MT-1:0]  nand_w;
    logic [N_OUT-1:0] mem_w [N_MT];
    logic [N_OUT-1:0] res_w, pres_q;

    xbar_sop_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .phase_o (ph),
        .done_o  (emit),
        .idle_o  (idle)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '1;
            neg_q <= '1;
        end else if (ph == PH_INIT) begin
            pos_q <= '1;
            neg_q <= '1;
        end else if (ph == PH_LOAD) begin
            pos_q <= in_vec;
            neg_q <= ~in_vec;
        end
    end

    for (genvar m = 0; m < N_MT; m++) begin : g_row
        xbar_mt_row #(.N_IN(N_IN), .N_OUT(N_OUT)) u_row (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg_we_i   (cfg_we && idle && (cfg_idx == IDX_W'(m))),
            .cfg_mask_i (cfg_mask),
            .cfg_pol_i  (cfg_pol),
            .cfg_mem_i  (cfg_mem),
            .ph_i       (ph),
            .in_pos_i   (pos_q),
            .in_neg_i   (neg_q),
            .mem_o      (mem_w[m]),
            .nand_o     (nand_w[m])
        );
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_col
        logic [N_MT-1:0] col_mem;
        for (genvar m = 0; m < N_MT; m++) begin : g_tap
            assign col_mem[m] = mem_w[m][o];
        end
        xbar_out_col #(.N_MT(N_MT)) u_col (
            .clk    (clk),
            .rst_n  (rst_n),
            .ph_i   (ph),
            .nand_i (nand_w),
            .mem_i  (col_mem),
            .res_o  (res_w[o])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pres_q <= '0;
        else if (emit) pres_q <= res_w;
    end

    always_comb begin
        phase   = ph;
        done    = emit;
        out_vec = emit ? res_w : pres_q;
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!emit && !$past(emit)) |-> $stable(out_vec)); // R8
    AST_DONE_IN_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (phase == 3'd7)); // R7
endmodule

// File: tb/sim_xbar_sop_eval.sv
`timescale 1ns/1ps
module sim_xbar_sop_eval;
    localparam int NI = 3, NM = 4, NO = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_idx = '0;
    logic [NI-1:0] cfg_mask = '0, cfg_pol = '0;
    logic [NO-1:0] cfg_mem = '0;
    logic          start = 1'b0;
    logic [NI-1:0] in_vec = '0;
    logic [2:0]    phase;
    logic          done;
    logic [NO-1:0] out_vec;

    int checks = 0, errors = 0;
    logic [NI-1:0] b_mask [NM];
    logic [NI-1:0] b_pol  [NM];
    logic [NO-1:0] b_mem  [NM];
    logic [NO-1:0] last_res;

    always #10 clk = ~clk;

    xbar_sop_eval #(.N_IN(NI), .N_MT(NM), .N_OUT(NO)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_mask(cfg_mask), .cfg_pol(cfg_pol), .cfg_mem(cfg_mem),
        .start(start), .in_vec(in_vec), .phase(phase), .done(done), .out_vec(out_vec)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [NO-1:0] model(input logic [NI-1:0] x);
        logic [NO-1:0] r = '0;
        for (int m = 0; m < NM; m++) begin
            logic p = 1'b1;
            for (int i = 0; i < NI; i++)
                if (b_mask[m][i]) p = p & (b_pol[m][i] ? x[i] : ~x[i]);
            for (int o = 0; o < NO; o++)
                if (b_mem[m][o] && p) r[o] = 1'b1;
        end
        return r;
    endfunction

    task automatic wr(input int m, input logic [NI-1:0] mk, input logic [NI-1:0] pl, input logic [NO-1:0] mb);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 2'(m); cfg_mask = mk; cfg_pol = pl; cfg_mem = mb;
        b_mask[m] = mk; b_pol[m] = pl; b_mem[m] = mb;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // mode 0 plain, 1 start pulse while busy (R2), 2 cfg write while busy (R3)
    task automatic eval(input logic [NI-1:0] x, input int mode);
        logic [NO-1:0] exp = model(x);
        @(negedge clk);
        in_vec = x; start = 1'b1;
        for (int k = 1; k <= 7; k++) begin
            @(negedge clk);
            start = 1'b0;
            chk(phase == 3'(k), "R1 phase step", phase, k);
            chk(done == (k == 7), "R7 done timing", done, k == 7);
            if (k < 7) chk(out_vec == last_res, "R8 hold during run", out_vec, last_res);
            if (mode == 1 && k == 3) start = 1'b1;
            if (mode == 2 && k == 2) begin
                cfg_we = 1'b1; cfg_idx = 2'd0; cfg_mask = ~b_mask[0];
                cfg_pol = ~b_pol[0]; cfg_mem = ~b_mem[0];
            end
            if (mode == 2 && k == 3) cfg_we = 1'b0;
        end
        chk(out_vec == exp, "R4 R5 R6 R10 result", out_vec, exp);
        last_res = exp;
        @(negedge clk);
        chk(phase == 3'd0 && !done, "R1 return idle", phase, 0);
        chk(out_vec == exp, "R8 hold after emit", out_vec, exp);
        if (mode == 1) begin
            for (int j = 0; j < 8; j++) begin
                @(negedge clk);
                chk(phase == 3'd0 && !done, "R2 busy start ignored", phase, 0);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        last_res = '0;
        for (int m = 0; m < NM; m++) begin b_mask[m] = '0; b_pol[m] = '0; b_mem[m] = '0; end
        repeat (3) @(negedge clk);
        chk(phase == 3'd0, "R9 reset phase", phase, 0);
        chk(done == 1'b0, "R9 reset done", done, 0);
        chk(out_vec == '0, "R9 reset out", out_vec, 0);
        rst_n = 1'b1;
        // config A: mixed literals and shared rows (R4, R6)
        wr(0, 3'b011, 3'b001, 2'b01);
        wr(1, 3'b110, 3'b110, 2'b11);
        wr(2, 3'b101, 3'b000, 2'b10);
        wr(3, 3'b111, 3'b101, 2'b10);
        for (int x = 0; x < 8; x++) eval(3'(x), 0);
        // input change while idle must not move out_vec (R8)
        in_vec = ~in_vec;
        repeat (3) @(negedge clk);
        chk(out_vec == last_res, "R8 idle input change", out_vec, last_res);
        eval(3'b101, 1);
        eval(3'b010, 2);
        eval(3'b010, 0);
        // config B: empty mask row (R5), output 1 without members (R6)
        wr(0, 3'b000, 3'b000, 2'b01);
        wr(1, 3'b100, 3'b100, 2'b00);
        wr(2, 3'b010, 3'b000, 2'b00);
        wr(3, 3'b001, 3'b001, 2'b00);
        for (int x = 7; x >= 0; x--) eval(3'(x), 0);
        // config C: output 1 fed only by the empty row, output 0 single literal
        wr(0, 3'b000, 3'b111, 2'b10);
        wr(1, 3'b010, 3'b000, 2'b01);
        wr(2, 3'b000, 3'b000, 2'b00);
        wr(3, 3'b111, 3'b111, 2'b00);
        for (int x = 0; x < 8; x++) eval(3'(x ^ 5), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule